// File: doc/BRIEF.md
# Dual-Mode PWM Timer Channel

This block is one timer channel: an up-counter, a bank of four compare registers and four pulse-width-modulated output pins. Software writes the compare values through a small write port. A static configuration sets three things: the operating mode, which register acts as the period register, and a 4-bit action field for each register. Each action field gives a starting level and what to do on a match.

In paired mode the registers work in pairs. Registers 0 and 1 drive pin 0, and registers 2 and 3 drive pin 2. Each match sets, clears or toggles the pair's pin, so one register places the rising edge and the other the falling edge. In cycle/duty mode one selected register sets the period: its match sends the counter back to zero and returns every other pin to its starting level. Each remaining register sets the duty point of its own pin.

Top module: `pwm_dual_chan`

## Requirements
- R1: While `cnt_en_i` is high the counter rises by one on each clock, and in paired mode it wraps from 0xFFFF to 0. While `cnt_en_i` is low it holds its value.
- R2: With `wr_en_i` high, a clock edge loads `wr_data_i` into the compare register picked by `wr_addr_i`. Addresses 0 to 3 select registers 0 to 3.
- R3: The action field of register i is `act_i[4i+3:4i]`. Bit 2 is the starting level (0 low, 1 high). Bits 1:0 are the match action: 00 none, 01 drive low, 10 drive high, 11 toggle. Bit 3 has no effect.
- R4: In paired mode (`mode_i`=0), pin 0 is driven by registers 0/1 and pin 2 by registers 2/3. A match on a register (counter equal to its value while counting) applies that register's own action to its pair's pin at the same clock edge.
- R5: In paired mode, pins 1 and 3 are low.
- R6: In paired mode, when both registers of a pair hold the same value, their match leaves the pair's pin unchanged.
- R7: In cycle/duty mode (`mode_i`=1), a match on register `cyc_sel_i` brings the counter to 0 at that clock edge. At the same edge every other pin goes to its own starting level.
- R8: In cycle/duty mode, a match on a register other than the cycle register applies that register's action to the pin with the same index.
- R9: In cycle/duty mode, a pin whose register equals the cycle register keeps its level on that match, including at the counter clear.
- R10: In cycle/duty mode, the pin that shares its index with the cycle register is low.
- R11: While `cnt_en_i` is low, a change on `mode_i`, `cyc_sel_i` or `act_i` loads every driven pin with its starting level at the next clock edge. Pins that are not driven go low.
- R12: Asynchronous reset clears the counter, the compare registers and all pins to 0.
- R13: While `cnt_en_i` is low and the configuration is unchanged, the pins hold their levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable |
| mode_i | input | 1 | 0 paired, 1 cycle/duty |
| cyc_sel_i | input | 2 | Index of the cycle register in cycle/duty mode |
| act_i | input | 16 | Four 4-bit action fields, register i at bits 4i+3:4i |
| wr_en_i | input | 1 | Compare register write strobe |
| wr_addr_i | input | 2 | Compare register index |
| wr_data_i | input | 16 | Compare value |
| pwm_o | output | 4 | Pin levels, bit i is pin i |
| cnt_o | output | 16 | Counter value |

## Verification
The bench targets four corner cases:
- Equal compare values, both inside a pair and between a duty register and the cycle register. A design that let a match act there would toggle the pin, or reset it to its starting level, instead of holding it.
- The cycle match landing in the same clock edge as a clear. A design with an extra register stage would show a count of 5 where 0 is expected.
- The counter wrap after 65536 counts. A design with the wrong width or a misplaced wrap would miss the late rising edge.
- A configuration change while stopped. A design without the reload would leave stale levels; one that reloads while stopped with nothing changed would lose the held levels.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;
  typedef enum logic {MODE_PAIR = 1'b0, MODE_CYC = 1'b1} pwm_mode_e;
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TGL  = 2'b11
  } pwm_act_e;

  localparam int unsigned ACT_W    = 4;
  localparam int unsigned INIT_BIT = 2;

  function automatic logic apply_act(input logic cur, input logic [1:0] code);
    logic nxt;
    unique case (pwm_act_e'(code))
      ACT_LOW:  nxt = 1'b0;
      ACT_HIGH: nxt = 1'b1;
      ACT_TGL:  nxt = ~cur;
      default:  nxt = cur;
    endcase
    return nxt;
  endfunction
endpackage

// File: rtl/pwm_cmp_bank.sv
module pwm_cmp_bank #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_REG = 4,
  localparam int unsigned AW     = $clog2(NUM_REG)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [AW-1:0]                   wr_addr_i,
  input  logic [CNT_W-1:0]                wr_data_i,
  input  logic [CNT_W-1:0]                cnt_i,
  output logic [NUM_REG-1:0][CNT_W-1:0]   cmp_o,
  output logic [NUM_REG-1:0]              match_o
);
  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    logic [CNT_W-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 val_q <= '0;
      else if (wr_en_i && wr_addr_i == AW'(g))     val_q <= wr_data_i;
    end
    assign cmp_o[g]   = val_q;
    assign match_o[g] = (cnt_i == val_q);
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (en_i)   cnt_q <= clr_i ? '0 : cnt_q + CNT_W'(1);
  end
  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_pin_ctrl.sv
module pwm_pin_ctrl
  import pwm_dual_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       drive_i,
  input  logic       load_i,
  input  logic       init_i,
  input  logic       clr_i,
  input  logic       hit_i,
  input  logic [1:0] act_i,
  output logic       pin_o
);
  logic pin_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pin_q <= 1'b0;
    else if (!drive_i)        pin_q <= 1'b0;
    else if (load_i || clr_i) pin_q <= init_i;
    else if (hit_i)           pin_q <= apply_act(pin_q, act_i);
  end
  assign pin_o = pin_q;
endmodule

// File: rtl/pwm_dual_chan.sv
module pwm_dual_chan
  import pwm_dual_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_REG = 4,
  localparam int unsigned AW     = $clog2(NUM_REG),
  localparam int unsigned FLD_W  = ACT_W * NUM_REG,
  localparam int unsigned CFG_W  = 1 + AW + FLD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cnt_en_i,
  input  logic               mode_i,
  input  logic [AW-1:0]      cyc_sel_i,
  input  logic [FLD_W-1:0]   act_i,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  output logic [NUM_REG-1:0] pwm_o,
  output logic [CNT_W-1:0]   cnt_o
);
  logic [NUM_REG-1:0][CNT_W-1:0] cmp;
  logic [NUM_REG-1:0]            match;
  logic [CNT_W-1:0]              cnt;
  logic [CFG_W-1:0]              cfg_q;
  logic                          cfg_load;
  logic                          cyc_mode;
  logic                          cyc_hit;
  logic [CNT_W-1:0]              cyc_val;

  assign cyc_mode = (pwm_mode_e'(mode_i) == MODE_CYC);
  assign cyc_hit  = cnt_en_i && match[cyc_sel_i];
  assign cyc_val  = cmp[cyc_sel_i];

  // stopped-state config change reloads starting levels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= {mode_i, cyc_sel_i, act_i};
  end
  assign cfg_load = !cnt_en_i && ({mode_i, cyc_sel_i, act_i} != cfg_q);

  pwm_cmp_bank #(.CNT_W(CNT_W), .NUM_REG(NUM_REG)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .cnt_i    (cnt),
    .cmp_o    (cmp),
    .match_o  (match)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cnt_en_i),
    .clr_i (cyc_mode && cyc_hit),
    .cnt_o (cnt)
  );

  for (genvar g = 0; g < NUM_REG; g++) begin : g_pin
    logic       pr_drv, pr_hit, pr_init;
    logic [1:0] pr_act;
    logic       cd_drv, cd_eq, cd_clr, cd_hit;
    logic       drv, clr, hit, init;
    logic [1:0] act;

    if (g % 2 == 0) begin : g_lead
      logic pr_eq;
      assign pr_eq   = (cmp[g] == cmp[g+1]);
      assign pr_drv  = 1'b1;
      assign pr_init = act_i[ACT_W*g + INIT_BIT];
      assign pr_hit  = cnt_en_i && (match[g] || match[g+1]) && !pr_eq;
      assign pr_act  = match[g] ? act_i[ACT_W*g +: 2] : act_i[ACT_W*(g+1) +: 2];
    end else begin : g_trail
      assign pr_drv  = 1'b0;
      assign pr_init = 1'b0;
      assign pr_hit  = 1'b0;
      assign pr_act  = 2'b00;
    end

    assign cd_drv = (cyc_sel_i != AW'(g));
    assign cd_eq  = (cmp[g] == cyc_val);
    assign cd_clr = cyc_hit && !cd_eq;
    assign cd_hit = cnt_en_i && match[g] && !cd_eq;

    assign drv  = cyc_mode ? cd_drv : pr_drv;
    assign clr  = cyc_mode ? cd_clr : 1'b0;
    assign hit  = cyc_mode ? cd_hit : pr_hit;
    assign init = cyc_mode ? act_i[ACT_W*g + INIT_BIT] : pr_init;
    assign act  = cyc_mode ? act_i[ACT_W*g +: 2] : pr_act;

    pwm_pin_ctrl u_pin (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .drive_i(drv),
      .load_i (cfg_load),
      .init_i (init),
      .clr_i  (clr),
      .hit_i  (hit),
      .act_i  (act),
      .pin_o  (pwm_o[g])
    );
  end

  assign cnt_o = cnt;
endmodule

// File: rtl/pwm_dual_chan_chk.sv
module pwm_dual_chan_chk #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_REG = 4,
  localparam int unsigned AW     = $clog2(NUM_REG)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cnt_en_i,
  input logic               mode_i,
  input logic [AW-1:0]      cyc_sel_i,
  input logic               wr_en_i,
  input logic [AW-1:0]      wr_addr_i,
  input logic [CNT_W-1:0]   wr_data_i,
  input logic [NUM_REG-1:0] pwm_o,
  input logic [CNT_W-1:0]   cnt_o
);
  logic [NUM_REG-1:0][CNT_W-1:0] sh;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh <= '0;
    else if (wr_en_i) sh[wr_addr_i] <= wr_data_i;
  end

  p_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !mode_i) |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> $stable(cnt_o));

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && mode_i && cnt_o == sh[cyc_sel_i]) |=> cnt_o == '0);

  p_cyc_pin_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |=> pwm_o[$past(cyc_sel_i)] == 1'b0);

  for (genvar g = 0; g < NUM_REG; g++) begin : g_chk
    if (g % 2 == 1) begin : g_odd
      p_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_i |=> pwm_o[g] == 1'b0);
    end else begin : g_even
      p_pair_eq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_en_i && !mode_i && sh[g] == sh[g+1] && cnt_o == sh[g]) |=> $stable(pwm_o[g]));
    end
    p_duty_eq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_en_i && mode_i && cyc_sel_i != AW'(g) && sh[g] == sh[cyc_sel_i] && cnt_o == sh[g])
      |=> $stable(pwm_o[g]));
  end
endmodule

bind pwm_dual_chan pwm_dual_chan_chk #(.CNT_W(CNT_W), .NUM_REG(NUM_REG)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_en_i (cnt_en_i),
  .mode_i   (mode_i),
  .cyc_sel_i(cyc_sel_i),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .pwm_o    (pwm_o),
  .cnt_o    (cnt_o)
);

// File: tb/pwm_dual_chan_tb.sv
module pwm_dual_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 9;

  typedef struct packed {
    logic        mode;
    logic [1:0]  cyc;
    logic [15:0] c3, c2, c1, c0;
    logic [15:0] act;
    logic [7:0]  n;
    logic [3:0]  pins;
    logic [15:0] cnt;
  } vec_t;

  // pin and count expected after n enabled clock edges
  localparam vec_t TBL [NVEC] = '{
    '{1'b0, 2'd0, 16'd3, 16'd3, 16'd5, 16'd2, 16'h3712, 8'd4, 4'b0101, 16'd4},
    '{1'b0, 2'd0, 16'd3, 16'd3, 16'd5, 16'd2, 16'h3712, 8'd6, 4'b0100, 16'd6},
    '{1'b0, 2'd0, 16'd4, 16'd1, 16'd3, 16'd0, 16'h3325, 8'd5, 4'b0001, 16'd5},
    '{1'b0, 2'd0, 16'd4, 16'd1, 16'd3, 16'd0, 16'h3325, 8'd3, 4'b0100, 16'd3},
    '{1'b1, 2'd3, 16'd4, 16'd1, 16'd4, 16'd2, 16'h0572, 8'd3, 4'b0011, 16'd3},
    '{1'b1, 2'd3, 16'd4, 16'd1, 16'd4, 16'd2, 16'h0572, 8'd5, 4'b0110, 16'd0},
    '{1'b1, 2'd3, 16'd4, 16'd1, 16'd4, 16'd2, 16'h0572, 8'd7, 4'b0010, 16'd2},
    '{1'b1, 2'd0, 16'd2, 16'd5, 16'd1, 16'd3, 16'h5430, 8'd3, 4'b0110, 16'd3},
    '{1'b1, 2'd0, 16'd2, 16'd5, 16'd1, 16'd3, 16'h5430, 8'd4, 4'b1100, 16'd0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cnt_en_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [1:0]  cyc_sel_i = '0;
  logic [15:0] act_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [3:0]  pwm_o;
  logic [15:0] cnt_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwm_dual_chan u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_en_i(cnt_en_i), .mode_i(mode_i),
    .cyc_sel_i(cyc_sel_i), .act_i(act_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .pwm_o(pwm_o), .cnt_o(cnt_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic setup(input logic m, input logic [1:0] cs, input logic [15:0] ac,
                       input logic [15:0] v0, input logic [15:0] v1,
                       input logic [15:0] v2, input logic [15:0] v3);
    @(negedge clk_i);
    rst_ni = 1'b0; cnt_en_i = 1'b0;
    mode_i = m; cyc_sel_i = cs; act_i = ac;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    write_reg(2'd0, v0);
    write_reg(2'd1, v1);
    write_reg(2'd2, v2);
    write_reg(2'd3, v3);
    #1;
  endtask

  task automatic run(input int n);
    @(negedge clk_i);
    cnt_en_i = 1'b1;
    repeat (n) @(negedge clk_i);
    cnt_en_i = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R12 reset state
    repeat (2) @(negedge clk_i);
    #1;
    check("R12 pins", 32'(pwm_o), 32'h0);
    check("R12 count", 32'(cnt_o), 32'h0);

    // table walk: R2 R3 R4 R5 R6 / R7 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      setup(TBL[i].mode, TBL[i].cyc, TBL[i].act, TBL[i].c0, TBL[i].c1, TBL[i].c2, TBL[i].c3);
      run(int'(TBL[i].n));
      check(TBL[i].mode ? "R7 R8 R9 R10 pins" : "R2 R3 R4 R5 R6 pins", 32'(pwm_o), 32'(TBL[i].pins));
      check(TBL[i].mode ? "R7 count" : "R1 count", 32'(cnt_o), 32'(TBL[i].cnt));
    end

    // R11 reload of starting levels after config change while stopped
    setup(1'b0, 2'd0, 16'h3712, 16'd2, 16'd5, 16'd3, 16'd3);
    check("R11 paired load", 32'(pwm_o), 32'h4);
    setup(1'b1, 2'd3, 16'h0572, 16'd2, 16'd4, 16'd1, 16'd4);
    check("R11 cycle load", 32'(pwm_o), 32'h6);

    // R13 stopped: pins and count hold
    run(3);
    check("R13 pins before", 32'(pwm_o), 32'h3);
    repeat (5) @(negedge clk_i);
    #1;
    check("R13 pins held", 32'(pwm_o), 32'h3);
    check("R1 count held", 32'(cnt_o), 32'd3);

    // R11 changing only the cycle register field (bit 3 irrelevant) reloads
    @(negedge clk_i);
    act_i = 16'h8572;
    @(negedge clk_i);
    #1;
    check("R11 reload on change", 32'(pwm_o), 32'h6);

    // R1 R4 wrap of the paired counter; R6 equal pair at 0 holds pin 2
    setup(1'b0, 2'd0, 16'h0012, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000);
    run(65535);
    check("R1 count before wrap", 32'(cnt_o), 32'hFFFF);
    check("R4 pins before wrap", 32'(pwm_o), 32'h0);
    run(1);
    check("R1 count wrapped", 32'(cnt_o), 32'h0);
    check("R4 late edge", 32'(pwm_o), 32'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule